// File: doc/BRIEF.md
# Speculation-Aware Out-of-Order Retirement Controller

This block tracks the instructions that the backend has taken in, each under a tag. It lets an instruction retire, and so hands back the backend resources it holds, while an older instruction is still incomplete. This is allowed only when that older instruction can no longer fault and can no longer be thrown away. A load that has finished address translation and passed its permission check cannot fault any more, so it stops holding back younger work even though its data has not yet arrived. An unresolved branch always holds back everything younger than it. Any other instruction that is not yet complete also holds back everything younger, because it may still raise an exception.

The front end offers one instruction per cycle together with its kind, and gets a tag back. The execution side then reports these events: completions, loads proven safe, branch resolutions with a mispredict flag, and exceptions. Every cycle the block reports up to a fixed number of retirements, oldest first. It also reports how many load-queue and store-queue entries those retirements free. Stores leave for memory only through these retirements. A mispredict or an exception discards the affected tags and raises a one-cycle flush that carries the squash boundary.

Top module: `orr_top`

## Requirements
- R1: After reset no retire lane is valid, no flush is raised, dispatch is ready and the next tag offered is 0.
- R2: Tags are handed out in increasing order modulo DEPTH. Once DEPTH tags are held, a non-NOP dispatch is refused (ready low).
- R3: A NOP (kind code 4) is accepted even when all tags are held. It takes no tag and never appears on a retire lane.
- R4: A completed instruction with nothing older blocking retires on the cycle after its last event. Retirements are reported oldest first from lane 0 upward, with at most LANES per cycle and the rest in following cycles.
- R5: A load (kind code 0) blocks younger retirement until its safe event. After that event, younger completed instructions retire even though the load is still incomplete. The load itself retires once it is complete.
- R6: An unresolved branch (kind code 2) blocks all younger retirement. A correct resolve completes the branch and releases it and the younger instructions behind it.
- R7: A mispredicted branch discards all younger tags, none of which ever retires. One cycle later, flush is high for one cycle with flush_tag equal to the branch tag and flush_incl low. Tag allocation resumes at the branch tag plus one.
- R8: An exception discards the faulting tag and all younger tags, none of which ever retires. One cycle later, flush is high with flush_tag equal to the faulting tag and flush_incl high. Tag allocation resumes at the faulting tag.
- R9: Each retire lane reports the kind of its instruction (store code 1, ALU code 3). free_ld_cnt and free_st_cnt count the loads and stores retiring in that cycle.
- R10: An incomplete store or ALU instruction blocks younger retirement until its completion event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_kind | input | 3 | 0 load, 1 store, 2 branch, 3 ALU, 4 NOP |
| disp_ready | output | 1 | Dispatch accepted when high together with disp_valid |
| disp_tag | output | TAGW | Tag given to the offered instruction |
| cmpl_valid | input | 1 | Completion event |
| cmpl_tag | input | TAGW | Tag that completed |
| ldok_valid | input | 1 | Load proven unable to fault |
| ldok_tag | input | TAGW | Tag of that load |
| br_valid | input | 1 | Branch resolved |
| br_tag | input | TAGW | Tag of that branch |
| br_mispred | input | 1 | Resolution was a mispredict |
| exc_valid | input | 1 | Exception raised |
| exc_tag | input | TAGW | Faulting tag |
| ret_valid | output | LANES | Per-lane retire strobe |
| ret_tag | output | LANES x TAGW | Per-lane retired tag |
| ret_kind | output | LANES x 3 | Per-lane retired kind |
| free_ld_cnt | output | CW | Load-queue entries freed this cycle |
| free_st_cnt | output | CW | Store-queue entries freed (stores committed) this cycle |
| flush_valid | output | 1 | One-cycle flush request |
| flush_tag | output | TAGW | Squash boundary tag |
| flush_incl | output | 1 | High when the boundary tag itself is discarded |

## Verification
The delicate case is a cycle that both retires and squashes. A mispredict resolve and the completion of an older instruction are driven on the same edge, with younger instructions already complete behind the branch. On the next cycle the bench expects the older instruction and the branch on the retire lanes and the flush raised with the branch as its boundary, all in that same cycle. It then watches further cycles to confirm that the complete younger tags never show up on a lane.

// File: rtl/orr_pkg.sv
// Package: shared kind encoding for the retirement controller.
// Assumes: kind codes fixed by the dispatch interface (0..4).
package orr_pkg;
    typedef enum logic [2:0] {
        K_LOAD   = 3'd0,
        K_STORE  = 3'd1,
        K_BRANCH = 3'd2,
        K_ALU    = 3'd3,
        K_NOP    = 3'd4
    } op_kind_e;
endpackage

// File: rtl/orr_tag_table.sv
// Module: per-tag state (valid, kind, complete, load-safe) and the derived
// ready / blocking vectors. Assumes events only name live tags and that an
// allocated slot is free (guaranteed by the pointer logic in the top).
module orr_tag_table
    import orr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TAGW  = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [TAGW-1:0]        alloc_tag,
    input  logic [2:0]             alloc_kind,
    input  logic                   cmpl_en,
    input  logic [TAGW-1:0]        cmpl_tag,
    input  logic                   safe_en,
    input  logic [TAGW-1:0]        safe_tag,
    input  logic                   res_en,
    input  logic [TAGW-1:0]        res_tag,
    input  logic [DEPTH-1:0]       kill_mask,
    input  logic [DEPTH-1:0]       ret_mask,
    output logic [DEPTH-1:0]       valid_o,
    output logic [DEPTH-1:0]       ready_o,
    output logic [DEPTH-1:0]       block_o,
    output logic [DEPTH-1:0][2:0]  kind_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic       v_q;
        logic       done_q;
        logic       safe_q;
        logic [2:0] k_q;
        logic       is_ld;

        // Slot register update: allocate, drop, or record events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                done_q <= 1'b0;
                safe_q <= 1'b0;
                k_q    <= K_NOP;
            end else if (alloc_en && alloc_tag == TAGW'(i)) begin
                v_q    <= 1'b1;
                done_q <= 1'b0;
                safe_q <= 1'b0;
                k_q    <= alloc_kind;
            end else if (kill_mask[i] || ret_mask[i]) begin
                v_q    <= 1'b0;
            end else begin
                if (cmpl_en && cmpl_tag == TAGW'(i)) done_q <= 1'b1;
                if (res_en  && res_tag  == TAGW'(i)) done_q <= 1'b1;
                if (safe_en && safe_tag == TAGW'(i)) safe_q <= 1'b1;
            end
        end

        // Loads block until proven safe, everything else until complete.
        always_comb begin
            is_ld      = (k_q == K_LOAD);
            valid_o[i] = v_q;
            kind_o[i]  = k_q;
            block_o[i] = v_q && (is_ld ? !safe_q : !done_q);
            ready_o[i] = v_q && done_q && (!is_ld || safe_q);
        end
    end

    // R4
    ret_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_mask & ~ready_o) == '0);
endmodule

// File: rtl/orr_retire_pick.sv
// Module: walks the tags from oldest (head) to youngest, stops at the first
// blocking tag and picks up to LANES ready tags, oldest in lane 0.
// Assumes: ready and blocking never both set on one tag; LANES >= 2.
module orr_retire_pick #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int TAGW  = $clog2(DEPTH),
    parameter int LW    = $clog2(LANES),
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [TAGW-1:0]            head,
    input  logic [DEPTH-1:0]           ready,
    input  logic [DEPTH-1:0]           block,
    output logic [LANES-1:0]           lane_vld,
    output logic [LANES-1:0][TAGW-1:0] lane_tag,
    output logic [DEPTH-1:0]           ret_mask
);
    logic [CW-1:0]   cnt;
    logic            stop;
    logic [TAGW-1:0] idx;

    // Age-ordered selection of the oldest eligible tags.
    always_comb begin
        lane_vld = '0;
        lane_tag = '0;
        ret_mask = '0;
        cnt      = '0;
        stop     = 1'b0;
        idx      = '0;
        for (int j = 0; j < DEPTH; j++) begin
            idx = head + TAGW'(j);
            if (!stop && ready[idx]) begin
                lane_vld[cnt[LW-1:0]] = 1'b1;
                lane_tag[cnt[LW-1:0]] = idx;
                ret_mask[idx]         = 1'b1;
                cnt                   = cnt + 1'b1;
                if (cnt == CW'(LANES)) stop = 1'b1;
            end
            if (block[idx]) stop = 1'b1;
        end
    end
endmodule

// File: rtl/orr_squash_ctrl.sv
// Module: turns mispredict / exception events into a kill mask and a
// squash boundary, and registers the one-cycle flush request.
// Assumes: event tags name live tags; the older of two events wins.
module orr_squash_ctrl #(
    parameter int DEPTH = 64,
    parameter int TAGW  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAGW-1:0]  head,
    input  logic             mis_en,
    input  logic [TAGW-1:0]  mis_tag,
    input  logic             exc_en,
    input  logic [TAGW-1:0]  exc_tag,
    output logic             sq_en,
    output logic [TAGW-1:0]  sq_age,
    output logic             sq_incl,
    output logic [DEPTH-1:0] kill_mask,
    output logic             flush_valid,
    output logic [TAGW-1:0]  flush_tag,
    output logic             flush_incl
);
    logic [TAGW-1:0] b_age;
    logic [TAGW-1:0] e_age;
    logic [TAGW-1:0] s_age;
    logic            pick_exc;

    // Boundary selection and age-relative kill mask.
    always_comb begin
        b_age    = mis_tag - head;
        e_age    = exc_tag - head;
        pick_exc = exc_en && (!mis_en || e_age <= b_age);
        sq_en    = exc_en || mis_en;
        sq_incl  = pick_exc;
        sq_age   = pick_exc ? e_age : b_age;
        kill_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s_age = TAGW'(i) - head;
            if (sq_en)
                kill_mask[i] = pick_exc ? (s_age >= e_age) : (s_age > b_age);
        end
    end

    // Registered flush request carrying the boundary tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_valid <= 1'b0;
            flush_tag   <= '0;
            flush_incl  <= 1'b0;
        end else begin
            flush_valid <= sq_en;
            flush_tag   <= head + sq_age;
            flush_incl  <= sq_incl;
        end
    end

    // R7
    mispred_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_en && !exc_en) |=> (flush_valid && !flush_incl && flush_tag == $past(mis_tag)));
    // R8
    exc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && !mis_en) |=> (flush_valid && flush_incl && flush_tag == $past(exc_tag)));
endmodule

// File: rtl/orr_top.sv
// Module: retirement controller top. Owns the head/tail ring pointers,
// dispatch acceptance, head advance over freed slots and retire outputs.
// Assumes: DEPTH is a power of two; one event of each type per cycle.
module orr_top
    import orr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int TAGW  = $clog2(DEPTH),
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [2:0]             disp_kind,
    output logic                   disp_ready,
    output logic [TAGW-1:0]        disp_tag,
    input  logic                   cmpl_valid,
    input  logic [TAGW-1:0]        cmpl_tag,
    input  logic                   ldok_valid,
    input  logic [TAGW-1:0]        ldok_tag,
    input  logic                   br_valid,
    input  logic [TAGW-1:0]        br_tag,
    input  logic                   br_mispred,
    input  logic                   exc_valid,
    input  logic [TAGW-1:0]        exc_tag,
    output logic [LANES-1:0]       ret_valid,
    output logic [LANES-1:0][TAGW-1:0] ret_tag,
    output logic [LANES-1:0][2:0]  ret_kind,
    output logic [CW-1:0]          free_ld_cnt,
    output logic [CW-1:0]          free_st_cnt,
    output logic                   flush_valid,
    output logic [TAGW-1:0]        flush_tag,
    output logic                   flush_incl
);
    localparam int PW = TAGW + 1;

    logic [PW-1:0]         head_q, tail_q, head_d, tail_d, occ;
    logic                  full, alloc_en, is_nop;
    logic [DEPTH-1:0]      valid, ready, block, kill_mask, ret_mask, live;
    logic [DEPTH-1:0][2:0] kind;
    logic                  sq_en, sq_incl;
    logic [TAGW-1:0]       sq_age;
    logic [PW-1:0]         sq_tail;

    // Dispatch acceptance; stalled during a squash cycle.
    always_comb begin
        occ        = tail_q - head_q;
        full       = occ[TAGW];
        is_nop     = (disp_kind == K_NOP);
        disp_ready = !sq_en && (is_nop || !full);
        alloc_en   = disp_valid && disp_ready && !is_nop;
        disp_tag   = tail_q[TAGW-1:0];
    end

    orr_tag_table #(.DEPTH(DEPTH), .TAGW(TAGW)) table_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_tag(tail_q[TAGW-1:0]), .alloc_kind(disp_kind),
        .cmpl_en(cmpl_valid), .cmpl_tag(cmpl_tag),
        .safe_en(ldok_valid), .safe_tag(ldok_tag),
        .res_en(br_valid), .res_tag(br_tag),
        .kill_mask(kill_mask), .ret_mask(ret_mask),
        .valid_o(valid), .ready_o(ready), .block_o(block), .kind_o(kind)
    );

    orr_retire_pick #(.DEPTH(DEPTH), .LANES(LANES), .TAGW(TAGW)) pick_i (
        .head(head_q[TAGW-1:0]), .ready(ready), .block(block),
        .lane_vld(ret_valid), .lane_tag(ret_tag), .ret_mask(ret_mask)
    );

    orr_squash_ctrl #(.DEPTH(DEPTH), .TAGW(TAGW)) squash_i (
        .clk(clk), .rst_n(rst_n), .head(head_q[TAGW-1:0]),
        .mis_en(br_valid && br_mispred), .mis_tag(br_tag),
        .exc_en(exc_valid), .exc_tag(exc_tag),
        .sq_en(sq_en), .sq_age(sq_age), .sq_incl(sq_incl), .kill_mask(kill_mask),
        .flush_valid(flush_valid), .flush_tag(flush_tag), .flush_incl(flush_incl)
    );

    // Retire lane kinds and per-cycle freed queue entries.
    always_comb begin
        free_ld_cnt = '0;
        free_st_cnt = '0;
        for (int l = 0; l < LANES; l++) begin
            ret_kind[l] = ret_valid[l] ? kind[ret_tag[l]] : 3'(K_NOP);
            if (ret_valid[l] && kind[ret_tag[l]] == K_LOAD)  free_ld_cnt = free_ld_cnt + 1'b1;
            if (ret_valid[l] && kind[ret_tag[l]] == K_STORE) free_st_cnt = free_st_cnt + 1'b1;
        end
    end

    // Next pointers: head skips freed slots, tail rewinds on squash.
    always_comb begin
        sq_tail = head_q + PW'(sq_age) + PW'(!sq_incl);
        tail_d  = sq_en ? sq_tail : tail_q + PW'(alloc_en);
        live    = valid & ~kill_mask & ~ret_mask;
        head_d  = sq_en ? sq_tail : tail_q;
        for (int j = DEPTH - 1; j >= 0; j--) begin
            if (live[TAGW'(head_q[TAGW-1:0] + TAGW'(j))]) head_d = head_q + PW'(j);
        end
    end

    // Ring pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q - head_q) <= PW'(DEPTH));
    // R8
    tail_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (disp_tag == flush_tag + TAGW'(!flush_incl)));
    for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
        // R4
        lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[l] |-> ret_valid[l-1]);
    end
endmodule

// File: tb/orr_top_tb.sv
module orr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int LANES = 4;
    localparam int TAGW  = 6;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [2:0] disp_kind = 3'd3;
    logic disp_ready;
    logic [TAGW-1:0] disp_tag;
    logic cmpl_valid = 1'b0, ldok_valid = 1'b0, br_valid = 1'b0, br_mispred = 1'b0, exc_valid = 1'b0;
    logic [TAGW-1:0] cmpl_tag = '0, ldok_tag = '0, br_tag = '0, exc_tag = '0;
    logic [LANES-1:0] ret_valid;
    logic [LANES-1:0][TAGW-1:0] ret_tag;
    logic [LANES-1:0][2:0] ret_kind;
    logic [CW-1:0] free_ld_cnt, free_st_cnt;
    logic flush_valid, flush_incl;
    logic [TAGW-1:0] flush_tag;

    int n_run = 0, n_fail = 0, cyc = 0;
    int ret_seen [DEPTH];

    orr_top dut_i (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .ldok_valid(ldok_valid), .ldok_tag(ldok_tag),
        .br_valid(br_valid), .br_tag(br_tag), .br_mispred(br_mispred),
        .exc_valid(exc_valid), .exc_tag(exc_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_kind(ret_kind),
        .free_ld_cnt(free_ld_cnt), .free_st_cnt(free_st_cnt),
        .flush_valid(flush_valid), .flush_tag(flush_tag), .flush_incl(flush_incl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Retire log and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (rst_n)
            for (int l = 0; l < LANES; l++)
                if (ret_valid[l]) ret_seen[ret_tag[l]]++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        disp_valid = 0; cmpl_valid = 0; ldok_valid = 0; br_valid = 0; br_mispred = 0; exc_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) ret_seen[i] = 0;
    endtask

    task automatic dispatch(input logic [2:0] k, output int tag);
        disp_valid = 1'b1; disp_kind = k; tag = disp_tag;
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic complete(input int t);
        cmpl_valid = 1'b1; cmpl_tag = TAGW'(t);
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(ret_valid == 0, "R1 ret_valid", ret_valid, 0);
        check(!flush_valid, "R1 flush", flush_valid, 0);
        check(disp_ready, "R1 ready", disp_ready, 1);
        check(disp_tag == 0, "R1 tag", disp_tag, 0);
    endtask

    task automatic t_bulk();
        int t;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            dispatch(i == 2 ? 3'd1 : 3'd3, t);
            check(t == i, "R2 seq tag", t, i);
        end
        for (int i = 1; i < 6; i++) complete(i);
        check(ret_valid == 0, "R10 older ALU blocks", ret_valid, 0);
        complete(0);
        check(ret_valid == 4'b1111, "R4 four lanes", ret_valid, 15);
        for (int l = 0; l < 4; l++) check(ret_tag[l] == l, "R4 lane order", ret_tag[l], l);
        check(ret_kind[2] == 3'd1, "R9 store kind", ret_kind[2], 1);
        check(ret_kind[0] == 3'd3, "R9 alu kind", ret_kind[0], 3);
        check(free_st_cnt == 1, "R9 store free", free_st_cnt, 1);
        @(negedge clk);
        check(ret_valid == 4'b0011, "R4 overflow lanes", ret_valid, 3);
        check(ret_tag[0] == 4 && ret_tag[1] == 5, "R4 overflow tags", ret_tag[0], 4);
        check(free_st_cnt == 0, "R9 no store", free_st_cnt, 0);
    endtask

    task automatic t_load();
        int t;
        do_reset();
        dispatch(3'd0, t); dispatch(3'd3, t);
        complete(1);
        idle(2);
        check(ret_seen[1] == 0, "R5 unproven load blocks", ret_seen[1], 0);
        ldok_valid = 1'b1; ldok_tag = 0;
        @(negedge clk); ldok_valid = 1'b0;
        check(ret_valid == 4'b0001 && ret_tag[0] == 1, "R5 bypass incomplete load", ret_tag[0], 1);
        idle(2);
        check(ret_seen[0] == 0, "R5 load not yet retired", ret_seen[0], 0);
        complete(0);
        check(ret_valid == 4'b0001 && ret_tag[0] == 0, "R5 load retires", ret_tag[0], 0);
        check(free_ld_cnt == 1, "R9 load free", free_ld_cnt, 1);
    endtask

    task automatic t_branch();
        int t;
        do_reset();
        dispatch(3'd2, t); dispatch(3'd3, t);
        complete(1);
        idle(3);
        check(ret_seen[1] == 0, "R6 branch blocks", ret_seen[1], 0);
        br_valid = 1'b1; br_tag = 0; br_mispred = 1'b0;
        @(negedge clk); br_valid = 1'b0;
        check(ret_valid == 4'b0011 && ret_tag[0] == 0 && ret_tag[1] == 1, "R6 release", ret_valid, 3);
        check(!flush_valid, "R6 no flush", flush_valid, 0);
    endtask

    task automatic t_store_block();
        int t;
        do_reset();
        dispatch(3'd1, t); dispatch(3'd3, t);
        complete(1);
        idle(3);
        check(ret_seen[1] == 0, "R10 store blocks", ret_seen[1], 0);
        complete(0);
        check(ret_valid == 4'b0011, "R10 release", ret_valid, 3);
    endtask

    task automatic t_mispred();
        int t;
        do_reset();
        dispatch(3'd3, t); dispatch(3'd2, t); dispatch(3'd3, t); dispatch(3'd3, t);
        complete(2); complete(3);
        cmpl_valid = 1'b1; cmpl_tag = 0;
        br_valid = 1'b1; br_tag = 1; br_mispred = 1'b1;
        @(negedge clk);
        cmpl_valid = 1'b0; br_valid = 1'b0; br_mispred = 1'b0;
        check(ret_valid == 4'b0011 && ret_tag[0] == 0 && ret_tag[1] == 1, "R7 older retire same cycle", ret_valid, 3);
        check(flush_valid && !flush_incl && flush_tag == 1, "R7 flush boundary", flush_tag, 1);
        check(disp_tag == 2, "R7 tail resume", disp_tag, 2);
        @(negedge clk);
        check(!flush_valid, "R7 one-cycle flush", flush_valid, 0);
        idle(3);
        check(ret_seen[2] == 0 && ret_seen[3] == 0, "R7 younger never retire", ret_seen[2] + ret_seen[3], 0);
    endtask

    task automatic t_exception();
        int t;
        do_reset();
        dispatch(3'd3, t); dispatch(3'd3, t); dispatch(3'd3, t);
        complete(0); complete(2);
        exc_valid = 1'b1; exc_tag = 1;
        @(negedge clk); exc_valid = 1'b0;
        check(flush_valid && flush_incl && flush_tag == 1, "R8 flush boundary", flush_tag, 1);
        check(disp_tag == 1, "R8 tail resume", disp_tag, 1);
        idle(3);
        check(ret_seen[0] == 1, "R8 older retired", ret_seen[0], 1);
        check(ret_seen[1] == 0 && ret_seen[2] == 0, "R8 fault and younger dropped", ret_seen[1] + ret_seen[2], 0);
    endtask

    task automatic t_full();
        int t, bad;
        do_reset();
        dispatch(3'd4, t);
        idle(2);
        check(disp_tag == 0 && ret_valid == 0, "R3 NOP takes no tag", disp_tag, 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            dispatch(3'd3, t);
            if (t != i) bad++;
        end
        check(bad == 0, "R2 tags in order", bad, 0);
        disp_kind = 3'd3;
        #1;
        check(!disp_ready, "R2 full refuses", disp_ready, 0);
        disp_kind = 3'd4;
        #1;
        check(disp_ready, "R3 NOP accepted when full", disp_ready, 1);
        dispatch(3'd4, t);
        complete(0);
        check(ret_valid == 4'b0001 && ret_tag[0] == 0, "R3 only real tag retires", ret_valid, 1);
        @(negedge clk);
        disp_kind = 3'd3;
        #1;
        check(disp_ready, "R2 ready after free", disp_ready, 1);
    endtask

    initial begin
        t_reset();
        t_bulk();
        t_load();
        t_branch();
        t_store_block();
        t_mispred();
        t_exception();
        t_full();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule